// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a received T1 line and raises a single remote (yellow) alarm flag for both framing families. An upstream framer hands it one strobe per received payload bit, with the channel number and the bit position inside the channel, plus a separate strobe for each bit of the facility data link. A free-running 1 ms tick supplies all timing. A format input picks the detection method, and a loss-of-frame input forces the detector back to its idle state.

In superframe mode the far end signals the alarm by forcing the second bit of every channel to zero. Time is split into 1 ms windows. A window counts as good when it saw at least one sample of that bit and the number of ones among those samples stays within a programmable penalty limit. The limit lets the alarm survive scattered line errors. The alarm is raised after an unbroken run of good windows and dropped after an unbroken run of bad ones. In extended superframe mode the alarm follows a fixed 16-bit code on the data link. The code is not error-tolerant, so short dropouts are expected and are left for software to smooth.

Every input is a valid-only strobe: the block takes a sample on every cycle its strobe is high and never applies back-pressure, because a line receiver cannot pause. There is therefore no ready signal, and the alarm output is a plain level.

Top module: `t1_yellow_alarm`

## Requirements
- R1: After reset `alarm` is 0.
- R2: In superframe mode only samples with `bit_pos` = 1 (the second bit, with positions counted from 0) are examined. A 1 ms window is good when it held at least one such sample and the count of ones among them is at most `pen_thr`. A window with no sample at all is bad.
- R3: In superframe mode `alarm` rises in the cycle after the tick that closes the 600th consecutive good window, and not before.
- R4: A bad window before the set count is reached restarts the count from zero.
- R5: Up to `pen_thr` ones in bit 1 within one window leave the window good. `pen_thr`+1 ones make it bad.
- R6: With the alarm set in superframe mode, `alarm` falls in the cycle after the tick that closes the 200th consecutive bad window. A good window in between restarts this count.
- R7: Samples at any `bit_pos` other than 1, and samples with `chan_idx` of 24 or more, have no effect on the alarm.
- R8: In extended superframe mode the last 16 link bits are compared, oldest first, against eight 0s followed by eight 1s (0x00FF with the oldest bit as the MSB). `alarm` rises in the cycle after the link bit that completes this pattern. The reversed pattern does not raise it.
- R9: No match is declared until 16 link bits have arrived since the last clear.
- R10: After a match, `alarm` falls in the cycle after the `hold_len`-th link bit that is not itself a match. Each new match restarts that count.
- R11: `lof` high for one cycle clears all state, and `alarm` is 0 in the next cycle.
- R12: A change of `fmt_esf` clears all state, and `alarm` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_esf | input | 1 | 0 selects superframe, 1 selects extended superframe |
| lof | input | 1 | Loss of frame; clears all state |
| bit_vld | input | 1 | Strobe for one received payload bit |
| rx_bit | input | 1 | Received payload bit value |
| chan_idx | input | 5 | Channel of the current bit, 0 to 23 |
| bit_pos | input | 3 | Position of the bit within its channel, 0 to 7 |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| fdl_vld | input | 1 | Strobe for one data link bit |
| fdl_bit | input | 1 | Data link bit value |
| pen_thr | input | 8 | Ones allowed per window in superframe mode |
| hold_len | input | 12 | Non-matching link bits before the link alarm clears |
| alarm | output | 1 | Remote alarm flag |

## Verification
The bench pushes the penalty count to exactly `pen_thr` and to one past it. A design with an off-by-one here would either miss the alarm under normal line noise or never restart its timer. It runs 599 and then 600 good windows, and 199 and then 200 bad ones, with a single interruption in each run. These runs catch a timer that sets or releases one window early or late, or that fails to restart. It feeds ones at other bit positions and on out-of-range channels, so a design that decodes the sample position wrongly loses the alarm. On the link side, the bench sends eight 1s straight after a clear and sends the reversed code. A shift register that trusts its reset contents, or that shifts the wrong way, would then raise a false alarm. It also checks that the hold count restarts on a repeated match, and that loss of frame or a format change drops the flag at once.

// File: rtl/t1ya_pkg.sv
package t1ya_pkg;
  typedef enum logic {
    FMT_SF  = 1'b0,
    FMT_ESF = 1'b1
  } frame_fmt_e;

  localparam int          LINK_PAT_W   = 16;
  localparam logic [15:0] LINK_YEL_PAT = 16'h00FF;
endpackage

// File: rtl/t1ya_sf_timer.sv
module t1ya_sf_timer #(
  parameter int SET_MS   = 600,
  parameter int REL_MS   = 200,
  parameter int PEN_W    = 8,
  parameter int CHAN_W   = 5,
  parameter int NUM_CH   = 24,
  parameter int BITPOS_W = 3,
  parameter int SIG_BIT  = 1,
  localparam int SET_W   = $clog2(SET_MS + 1),
  localparam int REL_W   = $clog2(REL_MS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                bit_vld,
  input  logic                rx_bit,
  input  logic [CHAN_W-1:0]   chan_idx,
  input  logic [BITPOS_W-1:0] bit_pos,
  input  logic                tick,
  input  logic [PEN_W-1:0]    pen_thr,
  output logic                alarm,
  output logic [SET_W-1:0]    set_cnt
);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SET_MS - 1);
  localparam logic [SET_W-1:0] SET_TOP  = SET_W'(SET_MS);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(REL_MS - 1);

  logic [PEN_W-1:0] pen;
  logic [REL_W-1:0] rel_cnt;
  logic             seen;
  logic             hit, hit_one, pen_full, win_good;

  // a sample counts only at the watched bit of a real channel
  assign hit      = en && bit_vld && (bit_pos == BITPOS_W'(SIG_BIT)) &&
                    (chan_idx < CHAN_W'(NUM_CH));
  assign hit_one  = hit && rx_bit;
  assign pen_full = &pen;
  assign win_good = seen && (pen <= pen_thr);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !en) begin
      pen     <= '0;
      seen    <= 1'b0;
      set_cnt <= '0;
      rel_cnt <= '0;
      alarm   <= 1'b0;
    end else if (tick) begin
      // window closes; a sample on the tick cycle opens the next one
      seen <= hit;
      pen  <= hit_one ? PEN_W'(1) : '0;
      if (win_good) begin
        rel_cnt <= '0;
        if (set_cnt != SET_TOP) set_cnt <= set_cnt + 1'b1;
        if (set_cnt == SET_LAST) alarm <= 1'b1;
      end else begin
        set_cnt <= '0;
        if (alarm) begin
          if (rel_cnt == REL_LAST) begin
            alarm   <= 1'b0;
            rel_cnt <= '0;
          end else begin
            rel_cnt <= rel_cnt + 1'b1;
          end
        end
      end
    end else begin
      if (hit) seen <= 1'b1;
      if (hit_one && !pen_full) pen <= pen + 1'b1;
    end
  end
endmodule

// File: rtl/t1ya_esf_match.sv
module t1ya_esf_match
  import t1ya_pkg::*;
#(
  parameter int HOLD_W = 12,
  localparam int FILL_W = $clog2(LINK_PAT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              fdl_vld,
  input  logic              fdl_bit,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              alarm
);
  localparam logic [FILL_W-1:0] FILL_TOP  = FILL_W'(LINK_PAT_W);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(LINK_PAT_W - 1);

  logic [LINK_PAT_W-1:0] sr;
  logic [LINK_PAT_W-1:0] sr_nxt;
  logic [FILL_W-1:0]     fill;
  logic [HOLD_W-1:0]     gap;
  logic                  match, gap_done;

  // oldest bit ends up at the MSB
  assign sr_nxt   = {sr[LINK_PAT_W-2:0], fdl_bit};
  assign match    = (fill >= FILL_LAST) && (sr_nxt == LINK_YEL_PAT);
  assign gap_done = ({1'b0, gap} + 1'b1) >= {1'b0, hold_len};

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !en) begin
      sr    <= '0;
      fill  <= '0;
      gap   <= '0;
      alarm <= 1'b0;
    end else if (fdl_vld) begin
      sr <= sr_nxt;
      if (fill != FILL_TOP) fill <= fill + 1'b1;
      if (match) begin
        alarm <= 1'b1;
        gap   <= '0;
      end else if (alarm) begin
        if (gap_done) begin
          alarm <= 1'b0;
          gap   <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/t1_yellow_alarm.sv
module t1_yellow_alarm
  import t1ya_pkg::*;
#(
  parameter int SET_MS   = 600,
  parameter int REL_MS   = 200,
  parameter int PEN_W    = 8,
  parameter int HOLD_W   = 12,
  parameter int CHAN_W   = 5,
  parameter int NUM_CH   = 24,
  parameter int BITPOS_W = 3,
  parameter int SIG_BIT  = 1,
  localparam int SET_W   = $clog2(SET_MS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_esf,
  input  logic                lof,
  input  logic                bit_vld,
  input  logic                rx_bit,
  input  logic [CHAN_W-1:0]   chan_idx,
  input  logic [BITPOS_W-1:0] bit_pos,
  input  logic                tick_1ms,
  input  logic                fdl_vld,
  input  logic                fdl_bit,
  input  logic [PEN_W-1:0]    pen_thr,
  input  logic [HOLD_W-1:0]   hold_len,
  output logic                alarm
);
  frame_fmt_e       fmt_q;
  logic             fmt_chg, clr_all;
  logic             sf_alarm, esf_alarm;
  logic [SET_W-1:0] sf_set_cnt;

  assign fmt_chg = frame_fmt_e'(fmt_esf) != fmt_q;
  assign clr_all = lof || fmt_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= FMT_SF;
    else        fmt_q <= frame_fmt_e'(fmt_esf);
  end

  t1ya_sf_timer #(
    .SET_MS(SET_MS), .REL_MS(REL_MS), .PEN_W(PEN_W), .CHAN_W(CHAN_W),
    .NUM_CH(NUM_CH), .BITPOS_W(BITPOS_W), .SIG_BIT(SIG_BIT)
  ) u_sf (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(fmt_q == FMT_SF),
    .bit_vld(bit_vld), .rx_bit(rx_bit), .chan_idx(chan_idx),
    .bit_pos(bit_pos), .tick(tick_1ms), .pen_thr(pen_thr),
    .alarm(sf_alarm), .set_cnt(sf_set_cnt)
  );

  t1ya_esf_match #(.HOLD_W(HOLD_W)) u_esf (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(fmt_q == FMT_ESF),
    .fdl_vld(fdl_vld), .fdl_bit(fdl_bit), .hold_len(hold_len),
    .alarm(esf_alarm)
  );

  assign alarm = (fmt_q == FMT_ESF) ? esf_alarm : sf_alarm;
endmodule

// File: rtl/t1ya_chk.sv
module t1ya_chk #(
  parameter int SET_MS = 600,
  parameter int SET_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lof,
  input logic             fmt_esf,
  input logic             fmt_q,
  input logic             tick_1ms,
  input logic             fdl_vld,
  input logic             alarm,
  input logic [SET_W-1:0] sf_set_cnt
);
  // R11
  lof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lof |=> !alarm);

  // R12
  fmt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_esf != fmt_q) |=> !alarm);

  // R3
  sf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alarm) && !fmt_q) |-> ($past(sf_set_cnt) == SET_W'(SET_MS - 1)));

  // R8
  esf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alarm) && fmt_q) |-> $past(fdl_vld));

  // R6
  sf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(alarm) && !fmt_q && !$past(lof) && $past(fmt_esf == fmt_q))
      |-> $past(tick_1ms));
endmodule

bind t1_yellow_alarm t1ya_chk #(.SET_MS(SET_MS), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lof(lof), .fmt_esf(fmt_esf), .fmt_q(fmt_q),
  .tick_1ms(tick_1ms), .fdl_vld(fdl_vld), .alarm(alarm),
  .sf_set_cnt(sf_set_cnt)
);

// File: tb/tb_t1_yellow_alarm.sv
module tb_t1_yellow_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_esf = 1'b0;
  logic        lof = 1'b0;
  logic        bit_vld = 1'b0;
  logic        rx_bit = 1'b0;
  logic [4:0]  chan_idx = '0;
  logic [2:0]  bit_pos = '0;
  logic        tick_1ms = 1'b0;
  logic        fdl_vld = 1'b0;
  logic        fdl_bit = 1'b0;
  logic [7:0]  pen_thr = 8'd2;
  logic [11:0] hold_len = 12'd5;
  logic        alarm;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];
  bit    m_exp;
  string m_tag;

  always #10 clk = ~clk;

  t1_yellow_alarm dut (
    .clk(clk), .rst_n(rst_n), .fmt_esf(fmt_esf), .lof(lof),
    .bit_vld(bit_vld), .rx_bit(rx_bit), .chan_idx(chan_idx),
    .bit_pos(bit_pos), .tick_1ms(tick_1ms), .fdl_vld(fdl_vld),
    .fdl_bit(fdl_bit), .pen_thr(pen_thr), .hold_len(hold_len),
    .alarm(alarm)
  );

  // monitor: compares queued expectations between clock edges
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      checks++;
      if (alarm !== m_exp) begin
        errors++;
        $display("FAIL %s: alarm=%b expected=%b", m_tag, alarm, m_exp);
      end
    end
  end

  task automatic expect_alarm(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic samp(input logic b, input logic [2:0] pos, input logic [4:0] ch);
    bit_vld = 1'b1; rx_bit = b; bit_pos = pos; chan_idx = ch;
    cyc();
    bit_vld = 1'b0;
  endtask

  task automatic tick();
    tick_1ms = 1'b1;
    cyc();
    tick_1ms = 1'b0;
  endtask

  // four samples of bit 1 with the first 'nones' set; optional ignored noise
  task automatic win(input int nones, input bit noise);
    for (int i = 0; i < 4; i++) samp(i < nones, 3'd1, 5'(i * 5));
    if (noise) begin
      samp(1'b1, 3'd0, 5'd3);
      samp(1'b1, 3'd5, 5'd7);
      samp(1'b1, 3'd1, 5'd26);
    end
    tick();
  endtask

  task automatic link(input logic b);
    fdl_vld = 1'b1; fdl_bit = b;
    cyc();
    fdl_vld = 1'b0;
  endtask

  task automatic link_n(input logic b, input int n);
    for (int i = 0; i < n; i++) link(b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();
    expect_alarm(1'b0, "R1");

    // superframe set path
    for (int w = 0; w < 300; w++) win(w % 3, w[0]);
    expect_alarm(1'b0, "R3 R5 early");
    win(3, 1'b0);
    expect_alarm(1'b0, "R4 R5 bad window");
    for (int w = 0; w < 599; w++) win(2, 1'b1);
    expect_alarm(1'b0, "R3 R4 R7 599 windows");
    win(2, 1'b1);
    expect_alarm(1'b1, "R3 R5 R7 600 windows");

    // superframe release path
    for (int w = 0; w < 199; w++) begin
      if (w[0]) tick(); else win(3, 1'b0);
    end
    expect_alarm(1'b1, "R6 R2 199 bad");
    win(0, 1'b0);
    expect_alarm(1'b1, "R6 good restarts");
    for (int w = 0; w < 199; w++) win(4, 1'b0);
    expect_alarm(1'b1, "R6 199 after restart");
    tick();
    expect_alarm(1'b0, "R6 R2 200 bad");

    // extended superframe
    fmt_esf = 1'b1;
    cyc();
    expect_alarm(1'b0, "R12 switch");
    link_n(1'b1, 8);
    expect_alarm(1'b0, "R9 fill guard");
    link_n(1'b0, 8);
    expect_alarm(1'b0, "R8 reversed");
    link_n(1'b1, 7);
    expect_alarm(1'b0, "R8 partial");
    link(1'b1);
    expect_alarm(1'b1, "R8 match");
    link_n(1'b1, 4);
    expect_alarm(1'b1, "R10 hold");
    link(1'b1);
    expect_alarm(1'b0, "R10 expire");

    hold_len = 12'd20;
    link_n(1'b0, 8); link_n(1'b1, 8);
    expect_alarm(1'b1, "R8 rematch");
    link_n(1'b1, 3); link_n(1'b0, 8); link_n(1'b1, 8);
    link_n(1'b1, 19);
    expect_alarm(1'b1, "R10 restart");
    link(1'b1);
    expect_alarm(1'b0, "R10 restart expire");

    link_n(1'b0, 8); link_n(1'b1, 8);
    expect_alarm(1'b1, "R8 before lof");
    lof = 1'b1;
    cyc();
    lof = 1'b0;
    expect_alarm(1'b0, "R11 lof");
    link_n(1'b1, 8);
    expect_alarm(1'b0, "R9 R11 after lof");
    link_n(1'b0, 8); link_n(1'b1, 8);
    expect_alarm(1'b1, "R8 after lof");
    fmt_esf = 1'b0;
    cyc();
    expect_alarm(1'b0, "R12 back to superframe");

    repeat (3) cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule